// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Aligner

The block takes a ten-byte instruction window read at the current program counter and an error flag from instruction memory. It splits the first byte into an operation code and a function code. From the operation code it works out whether a register-specifier byte follows and whether an eight-byte constant follows. It then pulls the register IDs and the constant out of the right byte positions and computes the fall-through address of the next instruction. Instructions are 1, 2, 9 or 10 bytes long.

The extraction is purely combinational. For test, a parameter (`REG_OUT`, default 1) puts a register stage on the outputs. Window byte k sits at bits `[8k+7:8k]` of `fetch_win`, and byte 0 is the byte at the program counter. When memory reports an error, the fetched bytes are discarded and a no-op is decoded in their place.

Top module: `fetch_aligner`

## Requirements
- R1: `icode` is bits [7:4] of window byte 0 and `ifun` is bits [3:0] of window byte 0.
- R2: A register byte is present only for icodes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB. When it is present, `ra` is bits [7:4] of byte 1 and `rb` is bits [3:0] of byte 1. Otherwise both `ra` and `rb` output 0xF.
- R3: An eight-byte constant is present only for icodes 0x3, 0x4, 0x5, 0x7 and 0x8. It starts at byte 2 when a register byte is present and at byte 1 otherwise. It is assembled little-endian, so its lowest-addressed byte is the least significant. When no constant is present, `valc` is 0.
- R4: `valp` equals `fetch_pc` + 1 + (1 if a register byte is present) + (8 if a constant is present), taken modulo 2^64.
- R5: When `imem_err` is 1, the window is ignored. The outputs are `icode`=0x1, `ifun`=0x0, `ra`=`rb`=0xF, `valc`=0, `valp`=`fetch_pc`+1 and `instr_ok`=1.
- R6: `instr_ok` is 1 exactly when the decoded `icode` is 0x0 through 0xB. For icodes 0xC through 0xF it is 0.
- R7: With `REG_OUT`=1, each output shows the result for the inputs sampled at the previous rising clock edge. While `rst` is high at an edge, the outputs load `icode`=0x1, `ifun`=0, `ra`=`rb`=0xF, `valc`=0, `valp`=0 and `instr_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 64 | Address of window byte 0 |
| fetch_win | input | 80 | Instruction window; byte k at bits [8k+7:8k] |
| imem_err | input | 1 | Instruction memory error flag |
| icode | output | 4 | Operation code |
| ifun | output | 4 | Function code |
| ra | output | 4 | First register ID (0xF means none) |
| rb | output | 4 | Second register ID (0xF means none) |
| valc | output | 64 | Constant word |
| valp | output | 64 | Fall-through address |
| instr_ok | output | 1 | Operation code is defined |

## Verification
The random patterns cover all sixteen operation codes with random trailing bytes. This separates the four length classes and shows whether the constant comes from offset 1 or offset 2. Directed windows use a distinct value in every byte, so that a constant taken from the wrong offset or assembled in the wrong byte order produces a visibly different value. A program counter close to the top of the address space exercises the modulo wrap of the fall-through address. Error-flagged fetches carrying live-looking windows show that the window bytes are ignored. Back-to-back changes around one clock edge show the one-cycle latency of the output register.

// File: rtl/fa_pkg.sv
package fa_pkg;

    localparam int ADDR_W     = 64;
    localparam int WORD_BYTES = 8;

    typedef enum logic [3:0] {
        OP_HALT = 4'h0, OP_NOP  = 4'h1, OP_RRMOV = 4'h2, OP_IRMOV = 4'h3,
        OP_RMMOV = 4'h4, OP_MRMOV = 4'h5, OP_ALU = 4'h6, OP_JUMP = 4'h7,
        OP_CALL = 4'h8, OP_RET  = 4'h9, OP_PUSH = 4'hA, OP_POP  = 4'hB
    } opc_e;

    localparam logic [3:0] FN_NONE = 4'h0;
    localparam logic [3:0] REG_NONE = 4'hF;

    typedef struct packed {
        logic [3:0] icode;
        logic [3:0] ifun;
        logic       need_reg;
        logic       need_const;
        logic       valid;
    } fa_ctrl_t;

    function automatic logic op_has_reg(input logic [3:0] c);
        case (c)
            OP_RRMOV, OP_IRMOV, OP_RMMOV, OP_MRMOV,
            OP_ALU, OP_PUSH, OP_POP: return 1'b1;
            default:                 return 1'b0;
        endcase
    endfunction

    function automatic logic op_has_const(input logic [3:0] c);
        case (c)
            OP_IRMOV, OP_RMMOV, OP_MRMOV, OP_JUMP, OP_CALL: return 1'b1;
            default:                                        return 1'b0;
        endcase
    endfunction

    function automatic logic op_defined(input logic [3:0] c);
        return c <= OP_POP;
    endfunction

endpackage

// File: rtl/fa_classify.sv
module fa_classify
    import fa_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    byte0,
    input  logic          imem_err,
    output fa_ctrl_t      ctrl
);
    logic [3:0] code_q;
    logic [3:0] fn_q;

    always_comb begin
        code_q = imem_err ? OP_NOP  : byte0[7:4];
        fn_q   = imem_err ? FN_NONE : byte0[3:0];
        ctrl.icode      = code_q;
        ctrl.ifun       = fn_q;
        ctrl.need_reg   = op_has_reg(code_q);
        ctrl.need_const = op_has_const(code_q);
        ctrl.valid      = op_defined(code_q);
    end

    // R5
    err_nop_chk: assert property (@(posedge clk) disable iff (rst)
        imem_err |-> (ctrl.icode == 4'h1 && ctrl.ifun == 4'h0 &&
                      !ctrl.need_reg && !ctrl.need_const));

    // R6
    undef_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.valid |-> (byte0[7:4] > 4'hB && !imem_err));

endmodule

// File: rtl/fa_extract.sv
module fa_extract
    import fa_pkg::*;
#(
    parameter int WBYTES = WORD_BYTES,
    localparam int WORD_W = 8 * WBYTES,
    localparam int TAIL_W = 8 * (WBYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TAIL_W-1:0] tail,
    input  fa_ctrl_t          ctrl,
    output logic [3:0]        ra,
    output logic [3:0]        rb,
    output logic [WORD_W-1:0] valc
);
    assign ra = ctrl.need_reg ? tail[7:4] : REG_NONE;
    assign rb = ctrl.need_reg ? tail[3:0] : REG_NONE;

    for (genvar k = 0; k < WBYTES; k++) begin : g_cbyte
        logic [7:0] pick;
        assign pick = ctrl.need_reg ? tail[8*(k+1) +: 8] : tail[8*k +: 8];
        assign valc[8*k +: 8] = ctrl.need_const ? pick : 8'h00;
    end

    // R2
    noreg_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.need_reg |-> (ra == 4'hF && rb == 4'hF));

    // R3
    noconst_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.need_const |-> (valc == '0));

endmodule

// File: rtl/fa_nextpc.sv
module fa_nextpc
    import fa_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int WBYTES = WORD_BYTES,
    localparam int LEN_W = $clog2(WBYTES + 3)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] pc,
    input  fa_ctrl_t      ctrl,
    output logic [AW-1:0] valp
);
    logic [LEN_W-1:0] ilen;
    logic [AW-1:0]    span;

    always_comb begin
        ilen = LEN_W'(1);
        if (ctrl.need_reg)   ilen = ilen + LEN_W'(1);
        if (ctrl.need_const) ilen = ilen + LEN_W'(WBYTES);
    end

    assign valp = pc + AW'(ilen);
    assign span = valp - pc;

    // R4
    len_class_chk: assert property (@(posedge clk) disable iff (rst)
        (span == AW'(1) || span == AW'(2) ||
         span == AW'(WBYTES + 1) || span == AW'(WBYTES + 2)));

endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner
    import fa_pkg::*;
#(
    parameter int AW      = ADDR_W,
    parameter int WBYTES  = WORD_BYTES,
    parameter bit REG_OUT = 1'b1,
    localparam int WORD_W = 8 * WBYTES,
    localparam int WIN_W  = 8 * (WBYTES + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     fetch_pc,
    input  logic [WIN_W-1:0]  fetch_win,
    input  logic              imem_err,
    output logic [3:0]        icode,
    output logic [3:0]        ifun,
    output logic [3:0]        ra,
    output logic [3:0]        rb,
    output logic [WORD_W-1:0] valc,
    output logic [AW-1:0]     valp,
    output logic              instr_ok
);
    fa_ctrl_t          ctrl;
    logic [3:0]        ra_c, rb_c;
    logic [WORD_W-1:0] valc_c;
    logic [AW-1:0]     valp_c;

    fa_classify u_cls (
        .clk(clk), .rst(rst), .byte0(fetch_win[7:0]),
        .imem_err(imem_err), .ctrl(ctrl)
    );

    fa_extract #(.WBYTES(WBYTES)) u_ext (
        .clk(clk), .rst(rst), .tail(fetch_win[WIN_W-1:8]), .ctrl(ctrl),
        .ra(ra_c), .rb(rb_c), .valc(valc_c)
    );

    fa_nextpc #(.AW(AW), .WBYTES(WBYTES)) u_npc (
        .clk(clk), .rst(rst), .pc(fetch_pc), .ctrl(ctrl), .valp(valp_c)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                icode    <= OP_NOP;
                ifun     <= FN_NONE;
                ra       <= REG_NONE;
                rb       <= REG_NONE;
                valc     <= '0;
                valp     <= '0;
                instr_ok <= 1'b0;
            end else begin
                icode    <= ctrl.icode;
                ifun     <= ctrl.ifun;
                ra       <= ra_c;
                rb       <= rb_c;
                valc     <= valc_c;
                valp     <= valp_c;
                instr_ok <= ctrl.valid;
            end
        end

        // R7
        reg_latency_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (valp == $past(valp_c) && valc == $past(valc_c)));
    end else begin : g_comb
        assign icode    = ctrl.icode;
        assign ifun     = ctrl.ifun;
        assign ra       = ra_c;
        assign rb       = rb_c;
        assign valc     = valc_c;
        assign valp     = valp_c;
        assign instr_ok = ctrl.valid;
    end

endmodule

// File: tb/tb_fetch_aligner.sv
module tb_fetch_aligner;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] fetch_pc = '0;
    logic [79:0] fetch_win = '0;
    logic        imem_err = 1'b0;
    logic [3:0]  icode, ifun, ra, rb;
    logic [63:0] valc, valp;
    logic        instr_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_aligner dut (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .fetch_win(fetch_win),
        .imem_err(imem_err), .icode(icode), .ifun(ifun), .ra(ra), .rb(rb),
        .valc(valc), .valp(valp), .instr_ok(instr_ok)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] wbyte(input logic [79:0] w, input int k);
        return w[8*k +: 8];
    endfunction

    // expected length from the opcode tables in R2/R3
    function automatic int exp_len(input logic [3:0] c);
        case (c)
            4'h3, 4'h4, 4'h5: return 10;
            4'h7, 4'h8:       return 9;
            4'h2, 4'h6, 4'hA, 4'hB: return 2;
            default:          return 1;
        endcase
    endfunction

    task automatic apply(input logic [63:0] pc, input logic [79:0] w, input logic err);
        logic [3:0]  e_code, e_fun, e_ra, e_rb;
        logic [63:0] e_c;
        int          len, base;
        @(negedge clk);
        fetch_pc = pc; fetch_win = w; imem_err = err;
        e_code = err ? 4'h1 : w[7:4];
        e_fun  = err ? 4'h0 : w[3:0];
        len = exp_len(e_code);
        e_ra = (len == 2 || len == 10) ? w[15:12] : 4'hF;
        e_rb = (len == 2 || len == 10) ? w[11:8]  : 4'hF;
        e_c = '0;
        if (len >= 9) begin
            base = (len == 10) ? 2 : 1;
            for (int k = 7; k >= 0; k--) e_c = {e_c[55:0], wbyte(w, base + k)};
        end
        @(posedge clk);
        #2;
        if (err) begin
            chk("R5 icode", {60'd0, icode}, 64'h1);
            chk("R5 ifun", {60'd0, ifun}, 64'h0);
            chk("R5 regs", {56'd0, ra, rb}, 64'hFF);
            chk("R5 valc", valc, 64'h0);
            chk("R5 valp", valp, pc + 64'd1);
            chk("R5 ok", {63'd0, instr_ok}, 64'h1);
        end else begin
            chk("R1 icode", {60'd0, icode}, {60'd0, e_code});
            chk("R1 ifun", {60'd0, ifun}, {60'd0, e_fun});
            chk("R2 regs", {56'd0, ra, rb}, {56'd0, e_ra, e_rb});
            chk("R3 valc", valc, e_c);
            chk("R4 valp", valp, pc + 64'(len));
            chk("R6 ok", {63'd0, instr_ok}, {63'd0, (e_code <= 4'hB)});
        end
    endtask

    function automatic logic [79:0] rnd_win();
        return {$urandom(), $urandom(), $urandom()} ;
    endfunction

    initial begin
        logic [79:0] seq_win;
        void'($urandom(32'h5EED_0F7C));
        for (int k = 0; k < 10; k++) seq_win[8*k +: 8] = 8'h10 + 8'(k * 17);

        repeat (2) @(posedge clk);
        #2;
        chk("R7 reset icode", {60'd0, icode}, 64'h1);
        chk("R7 reset regs", {56'd0, ra, rb}, 64'hFF);
        chk("R7 reset valc", valc, 64'h0);
        chk("R7 reset valp", valp, 64'h0);
        chk("R7 reset ok", {63'd0, instr_ok}, 64'h0);
        @(negedge clk);
        rst = 1'b0;

        // every opcode with distinct bytes
        for (int c = 0; c < 16; c++) begin
            seq_win[7:0] = {4'(c), 4'h5};
            apply(64'h0000_0000_0000_1000, seq_win, 1'b0);
        end
        // wrap near top of address space (R4)
        seq_win[7:0] = 8'h30;
        apply(64'hFFFF_FFFF_FFFF_FFFC, seq_win, 1'b0);
        seq_win[7:0] = 8'h80;
        apply(64'hFFFF_FFFF_FFFF_FFFF, seq_win, 1'b0);
        // error with live window (R5)
        seq_win[7:0] = 8'h40;
        apply(64'h0000_0000_0000_2000, seq_win, 1'b1);
        apply(64'hFFFF_FFFF_FFFF_FFFF, seq_win, 1'b1);

        // R7: output holds until the next rising edge
        @(negedge clk);
        fetch_pc = 64'h55; fetch_win = 80'h00; imem_err = 1'b0;
        @(posedge clk); #2;
        fetch_pc = 64'h77; fetch_win = 80'h30;
        #1;
        chk("R7 hold valp", valp, 64'h56);
        @(posedge clk); #2;
        chk("R7 update valp", valp, 64'h77 + 64'd10);

        for (int i = 0; i < 1500; i++) begin
            apply({$urandom(), $urandom()}, rnd_win(), ($urandom() % 8) == 0);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule